// File: doc/BRIEF.md
# A/D Conversion Channel Sequencer

This block is the digital control for an 8-bit multi-input analog-to-digital converter. A single configuration write sets a continuous-scan bit, a group-mode bit and a 4-bit channel code. That write starts a sequence of four conversion slots of fixed length. At the start of each slot the block raises a one-cycle start strobe. It also presents the code of the input to convert and a source class for that code. The converter answers with a done pulse and a data byte. The block stores that byte in one of four result registers.

In single-input mode the chosen input is converted four times, and the results fill registers 1 to 4 in turn. In group mode the two low code bits are ignored. The two high bits pick a bank of four codes, which are converted in ascending order into registers 1 to 4. After the fourth result is stored, a completion flag rises. With scan off, the block then goes idle. With scan on, it repeats the pass indefinitely, and the flag stays high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset there is no start strobe, the completion flag is 0 and all result registers are 0. Nothing is converted until the first configuration write.
- R2: A configuration write makes `conv_start` high in the cycle right after the write. After that, `conv_start` pulses once every SLOT_CYC cycles (default 32), one pulse per slot.
- R3: In single-input mode (`cfg_grp`=0), `conv_chan` equals `cfg_sel` in all four slots. Slot k result goes to register k+1, which is `res_flat[8k+7:8k]`.
- R4: In group mode (`cfg_grp`=1), `cfg_sel[1:0]` is ignored and `conv_chan` is `{cfg_sel[3:2], k}` in slot k. The lowest code of the bank lands in register 1 and the highest in register 4.
- R5: `conv_src` classifies `conv_chan`. It is 0 (external) for codes 0000 to 0111, 1 (internal reference) for 1100, 1101 and 1110, and 2 (reserved) for 10xx and 1111.
- R6: `seq_cmplt` goes high in the cycle after the fourth result is captured. With scan off, no further strobe is issued after the fourth slot.
- R7: With scan on, the four-slot pass restarts with no further write, so each input repeats every 4*SLOT_CYC cycles. `seq_cmplt` stays high, and the result registers take the new data.
- R8: A configuration write during a sequence aborts it. It clears `seq_cmplt` and restarts at slot 0 with the new settings.
- R9: A done pulse while no sequence runs, or a second done pulse in the same slot, leaves the result registers unchanged.
- R10: A reserved code keeps the normal slot timing and stores whatever data the converter returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe; starts a sequence |
| cfg_scan | input | 1 | Continuous-scan enable |
| cfg_grp | input | 1 | Group (four-input bank) mode |
| cfg_sel | input | 4 | Channel code |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | 4 | Code of the input being converted |
| conv_src | output | 2 | Source class: 0 external, 1 reference, 2 reserved |
| conv_done | input | 1 | Converter result-valid pulse |
| conv_data | input | DATA_W | Converter result |
| res_flat | output | 4*DATA_W | Result registers 1..4, register 1 in the low byte |
| seq_cmplt | output | 1 | Completion flag |

## Verification
A slot counter that is off by even one state moves the next `conv_start` away from its slot boundary. That error shows within one slot, at most SLOT_CYC cycles. A wrong slot index or a wrong bank decode puts a wrong code on `conv_chan` at the next strobe. It also stores data in the wrong byte of `res_flat`, which shows once the pass of four slots ends. An active or completion state that is held wrongly shows when a strobe appears after a non-scan pass. It also shows as a missing strobe at the start of the second scan pass, or as a flag that is not cleared in the cycle after a write.

// File: rtl/adseq_pkg.sv
package adseq_pkg;
   localparam int SEL_W   = 4;
   localparam int NUM_RES = 4;
   localparam int SLOT_IW = $clog2(NUM_RES);
   localparam int BANK_W  = SEL_W - SLOT_IW;

   typedef enum logic [1:0] {
      SRC_EXT  = 2'd0,
      SRC_REF  = 2'd1,
      SRC_RSVD = 2'd2
   } src_e;

   typedef struct packed {
      logic             scan;
      logic             grp;
      logic [SEL_W-1:0] sel;
   } cfg_t;
endpackage

// File: rtl/adseq_chan_decode.sv
module adseq_chan_decode
   import adseq_pkg::*;
(
   input  logic               grp,
   input  logic [SEL_W-1:0]   sel,
   input  logic [SLOT_IW-1:0] slot,
   output logic [SEL_W-1:0]   chan,
   output src_e               src
);
   logic [BANK_W-1:0] bank;

   assign bank = sel[SEL_W-1 -: BANK_W];

   always_comb begin
      if (grp) chan = {bank, slot};
      else     chan = sel;
   end

   always_comb begin
      unique casez (chan)
         4'b0???: src = SRC_EXT;
         4'b10??: src = SRC_RSVD;
         4'b1111: src = SRC_RSVD;
         default: src = SRC_REF;
      endcase
   end
endmodule

// File: rtl/adseq_slot_timer.sv
module adseq_slot_timer
   import adseq_pkg::*;
#(
   parameter int SLOT_CYC = 32,
   localparam int CNT_W = $clog2(SLOT_CYC)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               run,
   output logic               slot_first,
   output logic               slot_end,
   output logic               pass_end,
   output logic [SLOT_IW-1:0] slot
);
   localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(SLOT_CYC - 1);
   localparam logic [SLOT_IW-1:0] SLOT_LAST = SLOT_IW'(NUM_RES - 1);

   logic [CNT_W-1:0] cnt_q;

   if (SLOT_CYC < 4) begin : g_bad_slot
      $error("adseq_slot_timer: SLOT_CYC must be at least 4");
   end

   assign slot_first = run && (cnt_q == '0);
   assign slot_end   = run && (cnt_q == CNT_LAST);
   assign pass_end   = slot_end && (slot == SLOT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         slot  <= '0;
      end else if (restart) begin
         cnt_q <= '0;
         slot  <= '0;
      end else if (run) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            slot  <= slot + 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adseq_result_bank.sv
module adseq_result_bank
   import adseq_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap,
   input  logic [SLOT_IW-1:0]        slot,
   input  logic [DATA_W-1:0]         data,
   output logic [NUM_RES*DATA_W-1:0] res_flat
);
   for (genvar k = 0; k < NUM_RES; k++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= '0;
         else if (cap && (slot == SLOT_IW'(k)))
            r_q <= data;
      end
      assign res_flat[k*DATA_W +: DATA_W] = r_q;
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adseq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SLOT_CYC = 32
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_wr,
   input  logic                      cfg_scan,
   input  logic                      cfg_grp,
   input  logic [3:0]                cfg_sel,
   output logic                      conv_start,
   output logic [3:0]                conv_chan,
   output logic [1:0]                conv_src,
   input  logic                      conv_done,
   input  logic [DATA_W-1:0]         conv_data,
   output logic [NUM_RES*DATA_W-1:0] res_flat,
   output logic                      seq_cmplt
);
   if (DATA_W < 1) begin : g_bad_w
      $error("adc_seq_ctrl: DATA_W must be positive");
   end
   if (NUM_RES != 4 || SEL_W != 4) begin : g_bad_geom
      $error("adc_seq_ctrl: four result registers and a 4-bit code are required");
   end

   cfg_t               cfg_q;
   logic               active_q;
   logic               got_q;
   logic               cmplt_q;
   logic               slot_first, slot_end, pass_end;
   logic [SLOT_IW-1:0] slot;
   logic               cap;
   src_e               src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_wr) begin
         cfg_q.scan <= cfg_scan;
         cfg_q.grp  <= cfg_grp;
         cfg_q.sel  <= cfg_sel;
      end
   end

   adseq_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (cfg_wr),
      .run        (active_q),
      .slot_first (slot_first),
      .slot_end   (slot_end),
      .pass_end   (pass_end),
      .slot       (slot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active_q <= 1'b0;
      else if (cfg_wr)
         active_q <= 1'b1;
      else if (pass_end && !cfg_q.scan)
         active_q <= 1'b0;
   end

   assign cap = active_q && !cfg_wr && conv_done && !got_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         got_q <= 1'b0;
      else if (cfg_wr || slot_end)
         got_q <= 1'b0;
      else if (cap)
         got_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmplt_q <= 1'b0;
      else if (cfg_wr)
         cmplt_q <= 1'b0;
      else if (cap && (slot == SLOT_IW'(NUM_RES - 1)))
         cmplt_q <= 1'b1;
   end

   adseq_chan_decode u_dec (
      .grp  (cfg_q.grp),
      .sel  (cfg_q.sel),
      .slot (slot),
      .chan (conv_chan),
      .src  (src)
   );

   adseq_result_bank #(.DATA_W(DATA_W)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .slot     (slot),
      .data     (conv_data),
      .res_flat (res_flat)
   );

   assign conv_start = slot_first;
   assign conv_src   = src;
   assign seq_cmplt  = cmplt_q;
endmodule

// File: rtl/adseq_chk.sv
module adseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_wr,
   input logic       conv_start,
   input logic [3:0] conv_chan,
   input logic [1:0] conv_src,
   input logic       seq_cmplt
);
   AST_WR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> conv_start); // R2
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start && !cfg_wr |=> !conv_start); // R2
   AST_WR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !seq_cmplt); // R8
   AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      seq_cmplt && !cfg_wr |=> seq_cmplt); // R7
   AST_SRC_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_chan[3] |-> conv_src == 2'd0); // R5
   AST_SRC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      conv_chan[3:2] == 2'b10 |-> conv_src == 2'd2); // R5
endmodule

bind adc_seq_ctrl adseq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .conv_src   (conv_src),
   .seq_cmplt  (seq_cmplt)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   localparam int CLK_PER = 10;
   localparam int SLOT    = 32;
   localparam int DW      = 8;
   localparam int NV      = 8;
   // vector: {grp, sel[3:0], seed[7:0]}
   localparam logic [12:0] VECS [NV] = '{
      {1'b0, 4'b0101, 8'h10}, {1'b1, 4'b0110, 8'h21},
      {1'b1, 4'b0001, 8'h32}, {1'b1, 4'b1101, 8'h43},
      {1'b0, 4'b1000, 8'h54}, {1'b0, 4'b1110, 8'h65},
      {1'b0, 4'b0000, 8'h76}, {1'b1, 4'b1010, 8'h87}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 0, cfg_scan = 0, cfg_grp = 0;
   logic [3:0] cfg_sel = '0;
   logic conv_start, seq_cmplt, conv_done = 0;
   logic [3:0] conv_chan;
   logic [1:0] conv_src;
   logic [DW-1:0] conv_data = '0;
   logic [4*DW-1:0] res_flat;
   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] exp_res [4];

   always #(CLK_PER/2) clk = ~clk;

   adc_seq_ctrl #(.DATA_W(DW), .SLOT_CYC(SLOT)) u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] src_of(input logic [3:0] c);
      if (!c[3]) return 2'd0;
      if (!c[2] || c[1:0] == 2'b11) return 2'd2;
      return 2'd1;
   endfunction

   task automatic wr(input logic scan, input logic grp, input logic [3:0] sel);
      @(negedge clk);
      cfg_wr = 1; cfg_scan = scan; cfg_grp = grp; cfg_sel = sel;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   // runs one four-slot pass from a strobe negedge; ends at the next slot boundary
   task automatic pass(input string req, input logic grp, input logic [3:0] sel,
                       input logic [7:0] seed, input bit dbl);
      for (int s = 0; s < 4; s++) begin
         logic [3:0] ce;
         ce = grp ? {sel[3:2], 2'(s)} : sel;
         chk({req, " R2 start"}, 32'(conv_start), 1);
         chk({req, grp ? " R4 chan" : " R3 chan"}, 32'(conv_chan), 32'(ce));
         chk({req, " R5 src"}, 32'(conv_src), 32'(src_of(ce)));
         repeat (3) @(negedge clk);
         chk({req, " R2 no strobe mid-slot"}, 32'(conv_start), 0);
         conv_done = 1; conv_data = seed + 8'(s * 17);
         exp_res[s] = conv_data;
         @(negedge clk);
         if (dbl) conv_data = 8'hEE; // R9 second done ignored
         else conv_done = 0;
         @(negedge clk);
         conv_done = 0;
         repeat (SLOT - 5) @(negedge clk);
      end
      for (int k = 0; k < 4; k++)
         chk({req, " R3/R4 result"}, 32'(res_flat[k*DW +: DW]), 32'(exp_res[k]));
      chk({req, " R6 flag"}, 32'(seq_cmplt), 1);
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state and idle
      chk("R1 flag", 32'(seq_cmplt), 0);
      chk("R1 results", res_flat, 0);
      repeat (40) @(negedge clk);
      chk("R1 no strobe", 32'(conv_start), 0);
      // R9 done while idle ignored
      conv_done = 1; conv_data = 8'h5A; @(negedge clk); conv_done = 0;
      @(negedge clk);
      chk("R9 idle done", res_flat, 0);

      // table walk, non-scan; R10 via reserved codes
      for (int v = 0; v < NV; v++) begin
         wr(1'b0, VECS[v][12], VECS[v][11:8]);
         pass("R10 vec", VECS[v][12], VECS[v][11:8], VECS[v][7:0], 1'b0);
         chk("R6 stops", 32'(conv_start), 0);
         repeat (SLOT) @(negedge clk);
         chk("R6 idle", 32'(conv_start), 0);
      end

      // R9 second done in the same slot
      wr(1'b0, 1'b0, 4'b0011);
      pass("R9 dbl", 1'b0, 4'b0011, 8'h90, 1'b1);

      // R8 abort: flag set now; write mid-sequence clears and restarts
      wr(1'b0, 1'b1, 4'b0100);
      chk("R8 flag clr", 32'(seq_cmplt), 0);
      repeat (SLOT + 7) @(negedge clk);
      wr(1'b0, 1'b1, 4'b0000);
      chk("R8 restart chan", 32'(conv_chan), 32'h0);
      pass("R8 restarted", 1'b1, 4'b0000, 8'hA0, 1'b0);

      // R7 continuous scan: two passes, flag held, new data stored
      wr(1'b1, 1'b1, 4'b0111);
      pass("R7 p1", 1'b1, 4'b0111, 8'hB0, 1'b0);
      pass("R7 p2", 1'b1, 4'b0111, 8'hC3, 1'b0);
      chk("R7 next pass", 32'(conv_start), 1);
      chk("R7 flag held", 32'(seq_cmplt), 1);
      wr(1'b0, 1'b0, 4'b0000);
      chk("R8 scan abort flag", 32'(seq_cmplt), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule